// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits between a register interface and a NAND flash bus. Software loads an address, a byte count and two control words, then writes the first control word with its valid bit set. The block then drives one complete flash operation by itself: it sends the first opcode, the address bytes, an optional data phase, and an optional confirming second opcode. It then waits a fixed guard time, waits for the flash ready/busy line to go high again, and raises a completion interrupt.

The sequencer is a single state machine with seven states. `S_IDLE` goes to `S_CMD1` when a start is accepted. `S_CMD1` goes to `S_ADDR` when address cycles are due, and otherwise past it. `S_ADDR` runs once per address byte. Next comes `S_DATA` if a data phase was requested with a non-zero length, then `S_CMD2` if a second opcode is armed, and then `S_TWB`. `S_TWB` counts the guard cycles and goes to `S_WRDY`. `S_WRDY` returns to `S_IDLE` on ready, setting the done flag. Each flash bus cycle lasts one clock.

Read data is not captured and the ECC arithmetic is not done here. The block marks the write data phase for an ECC generator and pulses a clear for it.

Top module: `nand_cmd_seq`

Register map, as word index on `reg_addr`:
- 0: control word 1.
- 1: control word 2.
- 2: column address, 16 bits.
- 3: row address, 16 bits.
- 4: data length.
- 5: interrupt status, write 1 to clear.
- 6: interrupt mask.
- 7: status, with bit 0 showing busy.

Flash bus cycle kinds:
- Command: `fl_cle` and `fl_we` high.
- Address: `fl_ale` and `fl_we` high.
- Write data: only `fl_we` high.
- Read data: only `fl_re` high.

## Requirements
- R1: After reset the block is idle. Both `fl_ce_n` lines are high, no strobe is active, `irq` is 0, and the status and control word 1 registers read 0.
- R2: A write to control word 1 with bit 31 set, accepted while idle, starts a sequence. The first bus cycle is a command cycle carrying bits 7:0. Bit 19 selects the enable that is driven low: `fl_ce_n[1]` when the bit is 1, `fl_ce_n[0]` when it is 0. That enable stays low until the sequence ends, and both enables are high when idle.
- R3: Bits 29:27 of control word 1 hold (cycles−1)|4, where bit 29 marks that an address phase is present. With bit 29 set, 1 to 4 address cycles follow the first opcode. The bytes are sent in order: column low, column high, row low, row high. With bit 29 clear, no address cycle is sent.
- R4: When opcode 0x90 (identify) or 0x70 (status) has no address phase marked, one address cycle is still sent, carrying the column low byte.
- R5: Bit 26 requests a read data phase of `fl_re` cycles. Bit 25 requests a write data phase of `fl_we` cycles carrying `wr_byte`. Bit 26 wins if both are set. The phase lasts exactly as many cycles as the length register holds, and a length of 0 skips it.
- R6: When bit 8 of control word 2 is set, its bits 7:0 are sent as a command cycle after the address and data phases.
- R7: Status bit 31 (done) is set only after at least TWB cycles have passed since the last bus cycle and `fl_rb` has been sampled high. The bit becomes visible max(TWB+2, H+1) falling edges after the last bus cycle, where `fl_rb` rises H cycles after it.
- R8: Status bit 28 (data done) is set at the end of a data phase, and only when a data phase ran.
- R9: Writing 1 to status bits 31 or 28 clears them. `irq` is the OR of the status bits that are enabled in the mask.
- R10: Status bit 0 reads 1 from the start until the sequence ends. A write to control word 1 during that time is ignored: the register keeps its value and no second sequence starts.
- R11: `ecc_gen` is high during each write data cycle when bit 30 of control word 2 is set. Writing 0 to control word 2 gives one `ecc_clr` pulse, and any other value gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Masked interrupt |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we | output | 1 | Write strobe, one clock per byte |
| fl_re | output | 1 | Read strobe, one clock per byte |
| fl_dout | output | 8 | Flash output byte |
| fl_ce_n | output | 2 | Active-low chip enables |
| fl_rb | input | 1 | Flash ready (1) / busy (0) |
| wr_byte | input | 8 | Byte sent in write data cycles |
| ecc_gen | output | 1 | ECC generation marker for the write data phase |
| ecc_clr | output | 1 | ECC engine clear pulse |

## Verification
The assertions assume that `fl_rb` may be sampled at any time while idle. They also assume that no register write other than control word 1 arrives in the same cycle as a done event they check. The stimulus writes registers only at falling edges, one write per two cycles. It lowers `fl_rb` while a command is in flight and raises it a chosen number of cycles after the last bus cycle. It clears the status only after the done flag has been seen.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD1, S_ADDR, S_DATA, S_CMD2, S_TWB, S_WRDY
    } seq_state_e;

    localparam logic [2:0] RA_CTL1  = 3'd0;
    localparam logic [2:0] RA_CTL2  = 3'd1;
    localparam logic [2:0] RA_COL   = 3'd2;
    localparam logic [2:0] RA_ROW   = 3'd3;
    localparam logic [2:0] RA_LEN   = 3'd4;
    localparam logic [2:0] RA_ISTAT = 3'd5;
    localparam logic [2:0] RA_IMASK = 3'd6;
    localparam logic [2:0] RA_STAT  = 3'd7;

    localparam int C1_GO     = 31;
    localparam int C1_AMARK  = 29;
    localparam int C1_ACNT   = 27;
    localparam int C1_RD     = 26;
    localparam int C1_WR     = 25;
    localparam int C1_CESEL  = 19;
    localparam int C2_OP2V   = 8;
    localparam int C2_ECCGEN = 30;
    localparam int IS_DONE   = 31;
    localparam int IS_XFER   = 28;

    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_STATRD = 8'h70;

endpackage

// File: rtl/nand_seq_decode.sv
module nand_seq_decode
    import nand_seq_pkg::*;
#(
    parameter int ABYTES = 4
) (
    input  logic [31:0]               ctl1,
    input  logic [15:0]               col,
    input  logic [15:0]               row,
    input  logic [$clog2(ABYTES)-1:0] aidx,
    output logic [2:0]                n_addr,
    output logic [7:0]                abyte
);
    logic [7:0] bytes [ABYTES];
    logic [31:0] addr_word;

    assign addr_word = {row, col};

    for (genvar g = 0; g < ABYTES; g++) begin : g_byte
        assign bytes[g] = addr_word[8*g +: 8];
    end

    assign abyte = bytes[aidx];

    always_comb begin
        if (ctl1[C1_AMARK])
            n_addr = {1'b0, ctl1[C1_ACNT +: 2]} + 3'd1;
        else if (ctl1[7:0] == OP_IDENT || ctl1[7:0] == OP_STATRD)
            n_addr = 3'd1;
        else
            n_addr = 3'd0;
    end
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             seq_busy,
    input  logic             set_done,
    input  logic             set_xfer,
    output logic             start,
    output logic             busy,
    output logic [31:0]      ctl1_q,
    output logic [31:0]      ctl2_q,
    output logic [15:0]      col_q,
    output logic [15:0]      row_q,
    output logic [LEN_W-1:0] len_q,
    output logic             done_q,
    output logic             xfer_q,
    output logic             irq,
    output logic             ecc_clr
);
    logic [31:0] mask_q;
    logic [31:0] stat_w;
    logic wr_c1, wr_c2, wr_is;

    assign wr_c1  = reg_wr && reg_addr == RA_CTL1;
    assign wr_c2  = reg_wr && reg_addr == RA_CTL2;
    assign wr_is  = reg_wr && reg_addr == RA_ISTAT;
    assign busy   = seq_busy | start;
    assign stat_w = {done_q, 2'b00, xfer_q, 28'd0};
    assign irq    = |(stat_w & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1_q  <= '0;
            ctl2_q  <= '0;
            col_q   <= '0;
            row_q   <= '0;
            len_q   <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
            xfer_q  <= 1'b0;
            start   <= 1'b0;
            ecc_clr <= 1'b0;
        end else begin
            start   <= wr_c1 && reg_wdata[C1_GO] && !busy;
            ecc_clr <= wr_c2 && reg_wdata == 32'd0;
            if (wr_c1 && !busy) ctl1_q <= reg_wdata;
            if (wr_c2) ctl2_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_COL) col_q <= reg_wdata[15:0];
            if (reg_wr && reg_addr == RA_ROW) row_q <= reg_wdata[15:0];
            if (reg_wr && reg_addr == RA_LEN) len_q <= reg_wdata[LEN_W-1:0];
            if (reg_wr && reg_addr == RA_IMASK) mask_q <= reg_wdata;
            if (set_done) done_q <= 1'b1;
            else if (wr_is && reg_wdata[IS_DONE]) done_q <= 1'b0;
            if (set_xfer) xfer_q <= 1'b1;
            else if (wr_is && reg_wdata[IS_XFER]) xfer_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTL1:  reg_rdata = ctl1_q;
            RA_CTL2:  reg_rdata = ctl2_q;
            RA_COL:   reg_rdata = {16'd0, col_q};
            RA_ROW:   reg_rdata = {16'd0, row_q};
            RA_LEN:   reg_rdata = 32'(len_q);
            RA_ISTAT: reg_rdata = stat_w;
            RA_IMASK: reg_rdata = mask_q;
            RA_STAT:  reg_rdata = {31'd0, busy};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TWB   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      ctl1,
    input  logic [31:0]      ctl2,
    input  logic [15:0]      col,
    input  logic [15:0]      row,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wr_byte,
    input  logic             fl_rb,
    output logic             fl_cle,
    output logic             fl_ale,
    output logic             fl_we,
    output logic             fl_re,
    output logic [7:0]       fl_dout,
    output logic [1:0]       fl_ce_n,
    output logic             ecc_gen,
    output logic             seq_busy,
    output logic             set_done,
    output logic             set_xfer
);
    localparam int TW_W   = $clog2(TWB + 1);
    localparam int ABYTES = 4;
    localparam int AI_W   = $clog2(ABYTES);

    seq_state_e        state;
    logic [AI_W-1:0]   aidx;
    logic [LEN_W-1:0]  dcnt;
    logic [TW_W-1:0]   tcnt;
    logic [2:0]        n_addr;
    logic [7:0]        abyte;
    logic              rd_req, has_data;
    seq_state_e        after_addr, after_data;

    nand_seq_decode #(.ABYTES(ABYTES)) u_dec (
        .ctl1(ctl1), .col(col), .row(row), .aidx(aidx),
        .n_addr(n_addr), .abyte(abyte)
    );

    assign rd_req     = ctl1[C1_RD];
    assign has_data   = (ctl1[C1_RD] | ctl1[C1_WR]) && len != '0;
    assign after_data = ctl2[C2_OP2V] ? S_CMD2 : S_TWB;
    assign after_addr = has_data ? S_DATA : after_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            aidx  <= '0;
            dcnt  <= '0;
            tcnt  <= '0;
        end else begin
            if (state != S_ADDR) aidx <= '0;
            if (state != S_DATA) dcnt <= len - 1'b1;
            if (state != S_TWB)  tcnt <= TW_W'(TWB - 1);
            unique case (state)
                S_IDLE: if (start) state <= S_CMD1;
                S_CMD1: state <= (n_addr != 3'd0) ? S_ADDR : after_addr;
                S_ADDR: begin
                    aidx <= aidx + 1'b1;
                    if ({1'b0, aidx} == n_addr - 3'd1) state <= after_addr;
                end
                S_DATA: begin
                    if (dcnt == '0) state <= after_data;
                    else dcnt <= dcnt - 1'b1;
                end
                S_CMD2: state <= S_TWB;
                S_TWB: begin
                    if (tcnt == '0) state <= S_WRDY;
                    else tcnt <= tcnt - 1'b1;
                end
                S_WRDY: if (fl_rb) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_cle   = 1'b0;
        fl_ale   = 1'b0;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_dout  = 8'd0;
        ecc_gen  = 1'b0;
        set_done = 1'b0;
        set_xfer = 1'b0;
        fl_ce_n  = 2'b11;
        seq_busy = state != S_IDLE;
        if (seq_busy) fl_ce_n[ctl1[C1_CESEL]] = 1'b0;
        unique case (state)
            S_IDLE, S_TWB: ;
            S_CMD1: begin fl_cle = 1'b1; fl_we = 1'b1; fl_dout = ctl1[7:0]; end
            S_ADDR: begin fl_ale = 1'b1; fl_we = 1'b1; fl_dout = abyte; end
            S_DATA: begin
                set_xfer = dcnt == '0;
                if (rd_req) fl_re = 1'b1;
                else begin
                    fl_we   = 1'b1;
                    fl_dout = wr_byte;
                    ecc_gen = ctl2[C2_ECCGEN];
                end
            end
            S_CMD2: begin fl_cle = 1'b1; fl_we = 1'b1; fl_dout = ctl2[7:0]; end
            S_WRDY: set_done = fl_rb;
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TWB   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        fl_cle,
    output logic        fl_ale,
    output logic        fl_we,
    output logic        fl_re,
    output logic [7:0]  fl_dout,
    output logic [1:0]  fl_ce_n,
    input  logic        fl_rb,
    input  logic [7:0]  wr_byte,
    output logic        ecc_gen,
    output logic        ecc_clr
);
    logic             start, busy, seq_busy, set_done, set_xfer, done_q, xfer_q;
    logic [31:0]      ctl1_q, ctl2_q;
    logic [15:0]      col_q, row_q;
    logic [LEN_W-1:0] len_q;

    nand_seq_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_busy(seq_busy),
        .set_done(set_done), .set_xfer(set_xfer), .start(start), .busy(busy),
        .ctl1_q(ctl1_q), .ctl2_q(ctl2_q), .col_q(col_q), .row_q(row_q),
        .len_q(len_q), .done_q(done_q), .xfer_q(xfer_q), .irq(irq),
        .ecc_clr(ecc_clr)
    );

    nand_seq_fsm #(.LEN_W(LEN_W), .TWB(TWB)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ctl1(ctl1_q), .ctl2(ctl2_q),
        .col(col_q), .row(row_q), .len(len_q), .wr_byte(wr_byte), .fl_rb(fl_rb),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we), .fl_re(fl_re),
        .fl_dout(fl_dout), .fl_ce_n(fl_ce_n), .ecc_gen(ecc_gen),
        .seq_busy(seq_busy), .set_done(set_done), .set_xfer(set_xfer)
    );
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk
    import nand_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        fl_cle,
    input logic        fl_ale,
    input logic        fl_we,
    input logic        fl_re,
    input logic [1:0]  fl_ce_n,
    input logic        fl_rb,
    input logic        busy,
    input logic        done_q,
    input logic        set_done,
    input logic [31:0] ctl1_q
);
    // R2: never both enables low
    assert_one_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ce_n != 2'b00);
    // R2: a strobe only with an enable low
    assert_strobe_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cle | fl_ale | fl_we | fl_re) |-> fl_ce_n != 2'b11);
    // R3: address cycles are write cycles
    assert_ale_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ale |-> (fl_we && !fl_cle));
    // R5: read and write strobes exclusive
    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));
    // R7: done rises only after ready sampled high
    assert_done_after_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(fl_rb));
    // R9: write-one clears done when no new done arrives
    assert_w1c_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_ISTAT && reg_wdata[IS_DONE] && !set_done) |=> !done_q);
    // R10: control word 1 frozen while busy
    assert_ctl1_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == RA_CTL1) |=> $stable(ctl1_q));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we),
    .fl_re(fl_re), .fl_ce_n(fl_ce_n), .fl_rb(fl_rb), .busy(busy),
    .done_q(done_q), .set_done(set_done), .ctl1_q(ctl1_q)
);

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;
    localparam int TWB = 6;
    localparam int LEN_W = 12;
    localparam logic [2:0] A_C1 = 0, A_C2 = 1, A_COL = 2, A_ROW = 3,
                           A_LEN = 4, A_IS = 5, A_IM = 6, A_ST = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq, fl_cle, fl_ale, fl_we, fl_re, ecc_gen, ecc_clr;
    logic [7:0] fl_dout;
    logic [1:0] fl_ce_n;
    logic fl_rb = 1'b1;
    logic [7:0] wr_byte = '0;

    always #4 clk = ~clk;

    nand_cmd_seq #(.LEN_W(LEN_W), .TWB(TWB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we), .fl_re(fl_re),
        .fl_dout(fl_dout), .fl_ce_n(fl_ce_n), .fl_rb(fl_rb), .wr_byte(wr_byte),
        .ecc_gen(ecc_gen), .ecc_clr(ecc_clr)
    );

    int checks = 0, fails = 0;
    logic [11:0] ev [0:63];
    logic [1:0]  evce [0:63];
    int nev = 0, idle = 0, hold = 0, done_idle = 0, ecc_cnt = 0, clr_cnt = 0;
    bit active = 0, done_seen = 0;

    // bus monitor and ready/busy model
    always @(negedge clk) begin
        if (fl_cle | fl_ale | fl_we | fl_re) begin
            if (nev < 64) begin
                ev[nev]   = {(fl_cle ? 4'd1 : fl_ale ? 4'd2 : fl_re ? 4'd4 : 4'd3),
                             (fl_re ? 8'd0 : fl_dout)};
                evce[nev] = fl_ce_n;
            end
            nev++;
            idle = 0;
        end else idle++;
        if (ecc_gen) ecc_cnt++;
        if (ecc_clr) clr_cnt++;
        if (active && irq && !done_seen) begin
            done_seen = 1;
            done_idle = idle;
        end
        fl_rb <= active ? (idle >= hold) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_c1(input logic [7:0] op, input int acyc,
                                          input bit rd, input bit wr, input bit sel);
        logic [31:0] c;
        c = 32'h8000_0000 | 32'(op);
        if (acyc != 0) c |= 32'(4 | (acyc - 1)) << 27;
        c |= 32'(rd) << 26;
        c |= 32'(wr) << 25;
        c |= 32'(sel) << 19;
        return c;
    endfunction

    task automatic run_cmd(input logic [7:0] op, input int acyc, input bit rd,
                           input bit wr, input bit sel, input logic [15:0] col,
                           input logic [15:0] row, input int len, input bit op2v,
                           input logic [7:0] op2, input logic [7:0] wd,
                           input int hd, input bit eg);
        logic [11:0] ex [0:63];
        int nex, na, bad, exp_lat, guard;
        bit data_ran;
        logic [31:0] rv;
        logic [1:0] exp_ce;
        nex = 0;
        na = (acyc == 0 && (op == 8'h90 || op == 8'h70)) ? 1 : acyc;
        ex[nex++] = {4'd1, op};
        for (int i = 0; i < na; i++)
            ex[nex++] = {4'd2, (i < 2) ? col[8*i +: 8] : row[8*(i-2) +: 8]};
        data_ran = (rd || wr) && len != 0;
        if (data_ran)
            for (int i = 0; i < len; i++) ex[nex++] = rd ? 12'h400 : {4'd3, wd};
        if (op2v) ex[nex++] = {4'd1, op2};
        exp_ce = sel ? 2'b01 : 2'b10;

        wreg(A_COL, 32'(col));
        wreg(A_ROW, 32'(row));
        wreg(A_LEN, 32'(len));
        wreg(A_C2, (32'(eg) << 30) | (1 << 27) | (32'(op2v) << 8) | 32'(op2));
        @(posedge clk);
        wr_byte = wd; hold = hd; nev = 0; ecc_cnt = 0; done_seen = 0; active = 1;
        wreg(A_C1, mk_c1(op, acyc, rd, wr, sel));
        guard = 0;
        while (!done_seen && guard < 3000) begin @(posedge clk); guard++; end
        active = 0;
        chk(done_seen, "R7", "done seen", done_seen, 1);
        // R2 R3 R4 R5 R6: bus cycle trace
        chk(nev == nex, "R3", "bus cycle count", nev, nex);
        bad = 0;
        for (int i = 0; i < nex && i < nev; i++) begin
            if (ev[i] != ex[i]) begin
                bad++;
                $display("FAIL R5 cycle %0d actual=%0h expected=%0h", i, ev[i], ex[i]);
            end
            if (evce[i] != exp_ce) begin
                bad++;
                $display("FAIL R2 ce cycle %0d actual=%0h expected=%0h", i, evce[i], exp_ce);
            end
        end
        chk(bad == 0, "R6", "trace mismatches", bad, 0);
        exp_lat = (TWB + 2 > hd + 1) ? TWB + 2 : hd + 1;
        chk(done_idle == exp_lat, "R7", "done latency", done_idle, exp_lat);
        chk(ecc_cnt == ((wr && !rd && len != 0 && eg) ? len : 0), "R11", "ecc_gen cycles",
            ecc_cnt, (wr && !rd && len != 0 && eg) ? len : 0);
        rreg(A_IS, rv);
        chk(rv[28] == data_ran && rv[31], "R8", "status bits", rv, {data_ran, 28'd0} | 32'h8000_0000);
        wreg(A_IS, 32'h9000_0000);
        rreg(A_IS, rv);
        chk(rv == 0 && !irq, "R9", "status after clear", rv, 0);
        chk(fl_ce_n == 2'b11, "R2", "enables released", fl_ce_n, 3);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rv, c1a;
        int c0, guard;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fl_ce_n == 2'b11, "R1", "ce_n in reset", fl_ce_n, 3);
        chk(!(fl_cle | fl_ale | fl_we | fl_re), "R1", "strobes in reset",
            {fl_cle, fl_ale, fl_we, fl_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        rreg(A_ST, rv);
        chk(rv == 0, "R1", "status after reset", rv, 0);
        rreg(A_C1, rv);
        chk(rv == 0, "R1", "ctl1 after reset", rv, 0);
        wreg(A_IM, 32'h8000_0000);

        // directed corners
        run_cmd(8'h90, 0, 1, 0, 0, 16'h00A5, 16'h0, 5, 0, 8'h00, 8'h00, 3, 0); // R4 identify
        run_cmd(8'h70, 0, 1, 0, 1, 16'h0033, 16'h0, 1, 0, 8'h00, 8'h00, 0, 0); // R4 status
        run_cmd(8'h80, 4, 0, 1, 0, 16'h1234, 16'h5678, 6, 1, 8'h10, 8'h5A, 20, 1); // R6 R11 program
        run_cmd(8'h60, 3, 0, 0, 1, 16'hAAAA, 16'hBBCC, 4, 1, 8'hD0, 8'h00, 9, 0); // R5 no data
        run_cmd(8'h00, 4, 1, 1, 0, 16'h0102, 16'h0304, 3, 1, 8'h30, 8'hEE, 1, 1); // R5 rd wins
        run_cmd(8'h80, 2, 0, 1, 1, 16'h0F0E, 16'h0, 0, 0, 8'h00, 8'h77, 0, 1);  // R5 zero length

        // R11: ecc clear pulse
        c0 = clr_cnt;
        wreg(A_C2, 32'd0);
        repeat (2) @(negedge clk);
        chk(clr_cnt - c0 == 1, "R11", "ecc_clr on zero", clr_cnt - c0, 1);
        c0 = clr_cnt;
        wreg(A_C2, 32'h0000_0105);
        repeat (2) @(negedge clk);
        chk(clr_cnt - c0 == 0, "R11", "no ecc_clr on nonzero", clr_cnt - c0, 0);

        // R10: write during busy ignored
        wreg(A_LEN, 32'd4);
        wreg(A_C2, 32'd0);
        @(posedge clk);
        hold = 40; nev = 0; done_seen = 0; active = 1;
        c1a = mk_c1(8'h00, 2, 1, 0, 0);
        wreg(A_C1, c1a);
        rreg(A_ST, rv);
        chk(rv[0] == 1'b1, "R10", "busy flag", rv, 1);
        wreg(A_C1, mk_c1(8'hFF, 1, 0, 1, 1));
        rreg(A_C1, rv);
        chk(rv == c1a, "R10", "ctl1 kept", rv, c1a);
        guard = 0;
        while (!done_seen && guard < 3000) begin @(posedge clk); guard++; end
        active = 0;
        repeat (20) @(negedge clk);
        chk(nev == 7, "R10", "single sequence", nev, 7);
        rreg(A_ST, rv);
        chk(rv == 0, "R10", "idle after done", rv, 0);
        wreg(A_IS, 32'h9000_0000);

        // random commands
        for (int k = 0; k < 40; k++) begin
            logic [7:0] op;
            int sel_op;
            sel_op = $urandom % 6;
            op = (sel_op == 0) ? 8'h90 : (sel_op == 1) ? 8'h70 : 8'($urandom);
            run_cmd(op, $urandom % 5, 1'($urandom), 1'($urandom), 1'($urandom),
                    16'($urandom), 16'($urandom), $urandom % 9, 1'($urandom),
                    8'($urandom), 8'($urandom), $urandom % 20, 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule